// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a parallel TFT panel: a pixel clock, a one-cycle pixel enable in the functional clock domain, horizontal sync, vertical sync and data enable. It also drives the column and row of the current active pixel, which a downstream pixel path uses to fetch and format data. Every timing value arrives on configuration inputs in a compact offset encoding. Most fields carry their value minus one. The vertical porches carry their true line counts. The active width is counted in groups of 16 pixels. The row-count field is split across two inputs so that the eleventh bit can live in a separate control word.

All configuration fields, including the clock divisor, are copied into shadow registers only when a frame starts. Software may therefore rewrite them at any moment without tearing the picture. Vertical sync switches on the trailing edge of horizontal sync, not on its leading edge. The three output polarities can each be inverted. Turning the raster enable off does not cut the picture: the frame in progress runs to its end, and the block then signals that it has stopped.

Top module: `lcd_raster_timer`

## Requirements
- R1: `pix_ce` is a one-cycle pulse repeating every D functional clocks, where D is `clk_div`; values 0 and 1 are treated as 2. The first pulse after a start comes D cycles after the start edge.
- R2: A line consists of a sync region of `hs_width_m1`+1 pixels, then a back porch of `hback_m1`+1 pixels, then an active region of (`hact16_m1`+1)*16 pixels, then a front porch of `hfront_m1`+1 pixels. `de` is high only when the pixel lies in both the horizontal and the vertical active region.
- R3: Before polarity is applied, `hsync` is high during the sync region of every line while the raster runs.
- R4: A frame consists of `vs_width_m1`+1 sync lines, then `vback` back-porch lines (zero allowed), then {`lines_m1_msb`,`lines_m1_lo`}+1 active lines (up to 2048), then `vfront` front-porch lines (zero allowed).
- R5: Before polarity is applied, `vsync` changes only on the clock edge that ends the last sync pixel of a line. It is set on sync lines of the frame and cleared on all other lines.
- R6: `inv_hs`, `inv_vs` and `inv_pclk` invert `hsync`, `vsync` and `pclk_out` immediately. While stopped, each output rests at the level of its invert bit. Before inversion, `pclk_out` is low for the first floor(D/2) functional clocks of each pixel and high for the rest.
- R7: `px_x` and `px_y` give the position counted from the first active pixel and the first active line while `de` is high, and are 0 otherwise.
- R8: Configuration changes made during a frame take effect only at the next frame start.
- R9: `frame_end` pulses for one cycle after the last pixel of every frame. If `raster_en` is low at that point, the raster stops, `frame_done` pulses in the same cycle, and no pixel enables follow until the raster is enabled again.
- R10: After reset the raster is stopped: `pix_ce`, `de`, `frame_end` and `frame_done` are low, and the sync and clock outputs sit at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raster_en | input | 1 | Run request, sampled at start and at each frame end |
| clk_div | input | DIV_W | Pixel clock divisor (values below 2 act as 2) |
| hs_width_m1 | input | HFIELD_W | Hsync width minus one |
| hback_m1 | input | HFIELD_W | Horizontal back porch minus one |
| hact16_m1 | input | PPL_W | Active width in 16-pixel units minus one |
| hfront_m1 | input | HFIELD_W | Horizontal front porch minus one |
| vs_width_m1 | input | VSYNC_W | Vsync width in lines minus one |
| vback | input | VPORCH_W | Vertical back porch in lines |
| lines_m1_lo | input | LPP_W-1 | Active lines minus one, low bits |
| lines_m1_msb | input | 1 | Active lines minus one, top bit |
| vfront | input | VPORCH_W | Vertical front porch in lines |
| inv_hs | input | 1 | Invert hsync |
| inv_vs | input | 1 | Invert vsync |
| inv_pclk | input | 1 | Invert pixel clock |
| pclk_out | output | 1 | Pixel clock to the panel |
| pix_ce | output | 1 | Pixel enable, one functional clock per pixel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | PPL_W+4 | Active column |
| px_y | output | LPP_W | Active row |
| frame_end | output | 1 | Pulse at the end of every frame |
| frame_done | output | 1 | Pulse when the raster stops |

## Verification
All outputs are decoded from registers without further staging. Each result is therefore due in the functional clock that follows the edge on which the counters move: sync, enable and position change one cycle after the edge that ends a pixel, vsync moves one cycle after the pixel enable of the last sync pixel, and the stop pulses appear one cycle after the final pixel of the frame. The bench advances its behavioural model on the same rising edge as the design and compares every output on the falling edge, so each comparison sees the value that is due in that cycle. The tests change the configuration in the middle of a frame and drop the enable partway through a frame, which exercises the shadowing and the stop behaviour on exact cycles.

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer #(
  parameter int DIV_W    = 8,
  parameter int HFIELD_W = 10,
  parameter int PPL_W    = 7,
  parameter int VSYNC_W  = 6,
  parameter int VPORCH_W = 8,
  parameter int LPP_W    = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                raster_en,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic [HFIELD_W-1:0] hs_width_m1,
  input  logic [HFIELD_W-1:0] hback_m1,
  input  logic [PPL_W-1:0]    hact16_m1,
  input  logic [HFIELD_W-1:0] hfront_m1,
  input  logic [VSYNC_W-1:0]  vs_width_m1,
  input  logic [VPORCH_W-1:0] vback,
  input  logic [LPP_W-2:0]    lines_m1_lo,
  input  logic                lines_m1_msb,
  input  logic [VPORCH_W-1:0] vfront,
  input  logic                inv_hs,
  input  logic                inv_vs,
  input  logic                inv_pclk,
  output logic                pclk_out,
  output logic                pix_ce,
  output logic                hsync,
  output logic                vsync,
  output logic                de,
  output logic [PPL_W+3:0]    px_x,
  output logic [LPP_W-1:0]    px_y,
  output logic                frame_end,
  output logic                frame_done
);

  localparam int HC_W = $clog2(3 * (2 ** HFIELD_W) + 16 * (2 ** PPL_W) + 1);
  localparam int VC_W = $clog2((2 ** VSYNC_W) + 2 * (2 ** VPORCH_W) + (2 ** LPP_W) + 1);
  localparam int XW   = PPL_W + 4;
  localparam int YW   = LPP_W;
  localparam logic [HC_W-1:0]  H1 = HC_W'(1);
  localparam logic [VC_W-1:0]  V1 = VC_W'(1);
  localparam logic [DIV_W-1:0] D1 = DIV_W'(1);
  localparam logic [DIV_W-1:0] D2 = DIV_W'(2);

  logic             run, vs_q;
  logic [DIV_W-1:0] dcnt, d_s;
  logic [HC_W-1:0]  hcnt, hsw_s, hbp_s, act_s, hfp_s;
  logic [VC_W-1:0]  vcnt, vsw_s, vbp_s, lin_s, vfp_s;

  logic [HC_W-1:0] h_beg, h_fin, h_tot;
  logic [VC_W-1:0] v_beg, v_fin, v_tot;
  logic            h_last, v_last, f_last, load, h_act, v_act;

  assign h_beg = hsw_s + hbp_s;
  assign h_fin = h_beg + act_s;
  assign h_tot = h_fin + hfp_s;
  assign v_beg = vsw_s + vbp_s;
  assign v_fin = v_beg + lin_s;
  assign v_tot = v_fin + vfp_s;

  assign pix_ce = run && (dcnt == d_s - D1);
  assign h_last = hcnt == h_tot - H1;
  assign v_last = vcnt == v_tot - V1;
  assign f_last = pix_ce && h_last && v_last;
  assign load   = raster_en && (!run || f_last);

  assign h_act = (hcnt >= h_beg) && (hcnt < h_fin);
  assign v_act = (vcnt >= v_beg) && (vcnt < v_fin);
  assign de    = run && h_act && v_act;
  assign px_x  = de ? XW'(hcnt - h_beg) : '0;
  assign px_y  = de ? YW'(vcnt - v_beg) : '0;

  assign hsync    = (run && (hcnt < hsw_s)) ^ inv_hs;
  assign vsync    = vs_q ^ inv_vs;
  assign pclk_out = (run && (dcnt >= (d_s >> 1))) ^ inv_pclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_s   <= D2;
      hsw_s <= H1;
      hbp_s <= H1;
      act_s <= HC_W'(16);
      hfp_s <= H1;
      vsw_s <= V1;
      vbp_s <= '0;
      lin_s <= V1;
      vfp_s <= '0;
    end else if (load) begin
      d_s   <= (clk_div < D2) ? D2 : clk_div;
      hsw_s <= HC_W'(hs_width_m1) + H1;
      hbp_s <= HC_W'(hback_m1) + H1;
      act_s <= HC_W'({hact16_m1, 4'b0000}) + HC_W'(16);
      hfp_s <= HC_W'(hfront_m1) + H1;
      vsw_s <= VC_W'(vs_width_m1) + V1;
      vbp_s <= VC_W'(vback);
      lin_s <= VC_W'({lines_m1_msb, lines_m1_lo}) + V1;
      vfp_s <= VC_W'(vfront);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      dcnt       <= '0;
      hcnt       <= '0;
      vcnt       <= '0;
      vs_q       <= 1'b0;
      frame_end  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_end  <= f_last;
      frame_done <= f_last && !raster_en;
      if (!run) begin
        if (raster_en) begin
          run  <= 1'b1;
          dcnt <= '0;
          hcnt <= '0;
          vcnt <= '0;
          vs_q <= 1'b0;
        end
      end else begin
        dcnt <= pix_ce ? '0 : dcnt + D1;
        if (pix_ce) begin
          if (hcnt == hsw_s - H1)
            vs_q <= vcnt < vsw_s;
          if (h_last) begin
            hcnt <= '0;
            vcnt <= v_last ? '0 : vcnt + V1;
            if (v_last && !raster_en)
              run <= 1'b0;
          end else begin
            hcnt <= hcnt + H1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/lcd_raster_timer_chk.sv
module lcd_raster_timer_chk #(
  parameter int XW = 11,
  parameter int YW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ce,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          inv_hs,
  input logic          inv_vs,
  input logic [XW-1:0] px_x,
  input logic [YW-1:0] px_y,
  input logic          frame_end,
  input logic          frame_done
);

  p_ce_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> !pix_ce);

  p_de_outside_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == inv_hs));

  p_vs_on_trailing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync ^ inv_vs) |-> ($past(pix_ce) && $past(hsync ^ inv_hs)));

  p_pos_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (px_x == '0 && px_y == '0));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_done_with_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_end && !pix_ce && !de));

endmodule

bind lcd_raster_timer lcd_raster_timer_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
  .de(de), .inv_hs(inv_hs), .inv_vs(inv_vs), .px_x(px_x), .px_y(px_y),
  .frame_end(frame_end), .frame_done(frame_done)
);

// File: tb/sim_lcd_raster_timer.sv
`timescale 1ns/1ps
module sim_lcd_raster_timer;
  logic clk = 1'b0, rst_n = 1'b0, raster_en = 1'b0;
  logic [7:0] clk_div = '0;
  logic [9:0] hs_width_m1 = '0, hback_m1 = '0, hfront_m1 = '0;
  logic [6:0] hact16_m1 = '0;
  logic [5:0] vs_width_m1 = '0;
  logic [7:0] vback = '0, vfront = '0;
  logic [9:0] lines_m1_lo = '0;
  logic lines_m1_msb = 1'b0, inv_hs = 1'b0, inv_vs = 1'b0, inv_pclk = 1'b0;
  logic pclk_out, pix_ce, hsync, vsync, de, frame_end, frame_done;
  logic [10:0] px_x, px_y;

  always #2.5 clk = ~clk;

  lcd_raster_timer u0 (
    .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .clk_div(clk_div),
    .hs_width_m1(hs_width_m1), .hback_m1(hback_m1), .hact16_m1(hact16_m1),
    .hfront_m1(hfront_m1), .vs_width_m1(vs_width_m1), .vback(vback),
    .lines_m1_lo(lines_m1_lo), .lines_m1_msb(lines_m1_msb), .vfront(vfront),
    .inv_hs(inv_hs), .inv_vs(inv_vs), .inv_pclk(inv_pclk),
    .pclk_out(pclk_out), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
    .de(de), .px_x(px_x), .px_y(px_y), .frame_end(frame_end),
    .frame_done(frame_done)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_run = 0, m_dc = 0, m_h = 0, m_v = 0, m_vs = 0, m_fe = 0, m_fd = 0;
  int D = 2, HS = 1, HB = 1, ACT = 16, HF = 1, VS = 1, VB = 0, LN = 1, VF = 0;

  task automatic m_load();
    D   = (clk_div < 2) ? 2 : int'(clk_div);
    HS  = hs_width_m1 + 1;
    HB  = hback_m1 + 1;
    ACT = (hact16_m1 + 1) * 16;
    HF  = hfront_m1 + 1;
    VS  = vs_width_m1 + 1;
    VB  = vback;
    LN  = {lines_m1_msb, lines_m1_lo} + 1;
    VF  = vfront;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_dc = 0; m_h = 0; m_v = 0; m_vs = 0; m_fe = 0; m_fd = 0;
    end else begin
      m_fe = 0; m_fd = 0;
      if (m_run == 0) begin
        if (raster_en) begin
          m_run = 1; m_load(); m_dc = 0; m_h = 0; m_v = 0; m_vs = 0;
        end
      end else if (m_dc != D - 1) begin
        m_dc++;
      end else begin
        m_dc = 0;
        if (m_h == HS - 1) m_vs = (m_v < VS) ? 1 : 0;
        if (m_h == HS + HB + ACT + HF - 1) begin
          m_h = 0;
          if (m_v == VS + VB + LN + VF - 1) begin
            m_v = 0; m_fe = 1;
            if (raster_en) m_load();
            else begin m_run = 0; m_fd = 1; end
          end else m_v++;
        end else m_h++;
      end
    end
  end

  int de_cnt = 0, max_y = 0, fd_cnt = 0, ce_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e_de, e_hs;
      e_hs = (m_run != 0 && m_h < HS) ? 1 : 0;
      e_de = (m_run != 0 && m_h >= HS + HB && m_h < HS + HB + ACT &&
              m_v >= VS + VB && m_v < VS + VB + LN) ? 1 : 0;
      chk("R1 pix_ce", int'(pix_ce), (m_run != 0 && m_dc == D - 1) ? 1 : 0);
      chk("R3 hsync", int'(hsync), e_hs ^ int'(inv_hs));
      chk("R5 vsync", int'(vsync), m_vs ^ int'(inv_vs));
      chk("R2/R8 de", int'(de), e_de);
      chk("R6 pclk_out", int'(pclk_out),
          ((m_run != 0 && m_dc >= D / 2) ? 1 : 0) ^ int'(inv_pclk));
      chk("R7 px_x", int'(px_x), e_de != 0 ? m_h - HS - HB : 0);
      chk("R4/R7 px_y", int'(px_y), e_de != 0 ? m_v - VS - VB : 0);
      chk("R9 frame_end", int'(frame_end), m_fe);
      chk("R9 frame_done", int'(frame_done), m_fd);
      if (de) de_cnt++;
      if (de && int'(px_y) > max_y) max_y = int'(px_y);
      if (frame_done) fd_cnt++;
      if (pix_ce) ce_cnt++;
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 pix_ce", int'(pix_ce), 0);
    chk("R10 de", int'(de), 0);
    chk("R10 hsync", int'(hsync), 0);
    chk("R10 vsync", int'(vsync), 0);
    chk("R10 pclk_out", int'(pclk_out), 0);
    chk("R10 frame_done", int'(frame_done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // config A: D=3, line 2+1+16+3, frame 1+1+3+1 lines
    clk_div = 8'd3; hs_width_m1 = 10'd1; hback_m1 = 10'd0; hact16_m1 = 7'd0;
    hfront_m1 = 10'd2; vs_width_m1 = 6'd0; vback = 8'd1; lines_m1_lo = 10'd2;
    vfront = 8'd1; raster_en = 1'b1;
    repeat (500) @(negedge clk);

    // R8: rewrite mid-frame, R1: divisor 1 acts as 2, R6: all inverted, R4: zero porches
    clk_div = 8'd1; hs_width_m1 = 10'd0; hback_m1 = 10'd1; hact16_m1 = 7'd1;
    hfront_m1 = 10'd0; vs_width_m1 = 6'd2; vback = 8'd0; lines_m1_lo = 10'd1;
    vfront = 8'd0; inv_hs = 1'b1; inv_vs = 1'b1; inv_pclk = 1'b1;
    repeat (1000) @(negedge clk);

    // R9: drop enable mid-frame, frame must finish
    raster_en = 1'b0;
    fd_cnt = 0;
    while (!frame_done) @(negedge clk);
    ce_cnt = 0;
    repeat (60) @(negedge clk);
    chk("R9 single frame_done", fd_cnt, 1);
    chk("R9 idle no pix_ce", ce_cnt, 0);
    chk("R6 idle hsync level", int'(hsync), 1);
    chk("R6 idle pclk level", int'(pclk_out), 1);

    // config C: divisor 0 acts as 2, 1025 active lines via top bit
    inv_hs = 1'b0; inv_vs = 1'b0; inv_pclk = 1'b0;
    clk_div = 8'd0; hs_width_m1 = 10'd0; hback_m1 = 10'd0; hact16_m1 = 7'd0;
    hfront_m1 = 10'd0; vs_width_m1 = 6'd0; vback = 8'd0; vfront = 8'd0;
    lines_m1_lo = 10'd0; lines_m1_msb = 1'b1;
    de_cnt = 0; max_y = 0; fd_cnt = 0;
    raster_en = 1'b1;
    repeat (10) @(negedge clk);
    raster_en = 1'b0;
    while (!frame_done) @(negedge clk);
    @(negedge clk);
    chk("R4 last active row", max_y, 1024);
    chk("R2 de cycles in frame", de_cnt, 1025 * 16 * 2);
    chk("R9 frame_done count", fd_cnt, 1);
    finish_run();
  end
endmodule